// File: doc/BRIEF.md
# Eight-Digit Multiplexed LED Display Scanner

This block shows eight latched decimal digits on a time-shared seven-segment LED display. It visits one digit position at a time, starting at the most significant (D8) and working down to D1. For each position it drives a one-hot digit strobe, the seven segment lines and a decimal-point line. A multiplexed BCD bus carries the raw value of the digit being visited, so outside logic can latch it.

Each digit slot is measured in pulses of an external scan tick. A slot starts with a short dark gap, which stops ghosting between neighbouring digits, and then has a longer lit phase. The BCD bus moves to the new digit at the start of the gap, so it always settles before the strobe asserts.

Several features are built in:
- Leading zeros are blanked up to a movable decimal-point position.
- Overflow disables the blanking and is flagged on the decimal point of D8.
- Display test lights every segment.
- Display off darkens everything and overrides display test.
- Two parameters choose the active level of the strobes and of the segments, to suit either display polarity.

Top module: `led_scan_top`

## Requirements
- R1: After reset the scan starts at D8 and steps D8, D7, …, D1, then wraps back to D8. Digit k (D1 is k=0) is `digits_i[4k+3:4k]`, and strobe bit k belongs to Dk+1.
- R2: Each slot is GAP_TICKS ticks with all strobes, segments and the decimal point inactive, followed by ON_TICKS ticks with exactly the slot's strobe active. At most one strobe is ever active.
- R3: During a whole slot, gap included, `bcd_o` carries the raw digit value of that slot. It therefore leads the strobe by GAP_TICKS ticks. Blanking and display test never change it.
- R4: The scan state advances only on cycles where `scan_tick_i` is high. With the tick low, the strobes hold their value.
- R5: Segments are encoded `seg_o[6:0]` = {g,f,e,d,c,b,a} with a standard font. In hex, digits 0 to 9 are 3F 06 5B 4F 66 6D 7D 07 7F 6F. Codes 10 to 15 light no segment.
- R6: `dp_idx_i` selects the decimal-point digit (0 = D1 … 7 = D8). A zero is blanked only if it lies left of that digit and every digit to its left is also zero. The decimal-point digit and all digits to its right are always shown.
- R7: While `overflow_i` is high, no digit is blanked and the decimal point of D8 is lit.
- R8: The decimal point is lit on the digit selected by `dp_idx_i`.
- R9: Display test lights all seven segments and the decimal point on every lit digit.
- R10: Display off holds every strobe, segment and decimal point inactive and drives `bcd_o` to 0, even when display test is also high.
- R11: STROBE_ACTIVE_LOW inverts the strobes and SEG_ACTIVE_LOW inverts the segments and the decimal point. The BCD bus is not inverted.
- R12: During reset all strobes, segments and the decimal point are inactive and `bcd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scan_tick_i | input | 1 | Enable pulse that sets the time unit of each slot |
| digits_i | input | 32 | Eight packed BCD digits, D1 in the low nibble |
| dp_idx_i | input | 3 | Decimal-point digit index, 0 = D1 |
| overflow_i | input | 1 | Counter overflowed |
| disp_test_i | input | 1 | Display test request |
| disp_off_i | input | 1 | Display off request |
| strobe_o | output | 8 | Digit strobes, bit k drives Dk+1 |
| seg_o | output | 7 | Segments {g,f,e,d,c,b,a} |
| dp_o | output | 1 | Decimal-point segment |
| bcd_o | output | 4 | Multiplexed BCD value of the visited digit |

## Verification
The checker watches the following on every cycle:
- the strobes are never more than one-hot, and the segments stay dark whenever no strobe is active;
- display off darkens everything and clears the BCD bus;
- display test lights every segment on any lit digit;
- overflow lights the D8 decimal point;
- the strobes freeze while the tick is absent.

Only the bench's scenarios can show the rest, because checking them needs the digit data: the scan order and wrap, the exact gap and lit lengths, the BCD lead, the font values, and where blanking stops for a given decimal-point position. A second, inverted-polarity instance is compared against the first to cover the polarity parameters.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    // What one lit digit shows: segment pattern plus decimal point.
    typedef struct packed {
        seg_t seg;
        logic dp;
    } glyph_t;

    typedef enum logic [1:0] {
        SHOW_VALUE,
        SHOW_BLANK,
        SHOW_TEST
    } show_e;

    // Segment order {g,f,e,d,c,b,a}; non-decimal codes stay dark.
    function automatic seg_t bcd_to_seg(input bcd_t v);
        seg_t s;
        case (v)
            4'd0:    s = 7'b011_1111;
            4'd1:    s = 7'b000_0110;
            4'd2:    s = 7'b101_1011;
            4'd3:    s = 7'b100_1111;
            4'd4:    s = 7'b110_0110;
            4'd5:    s = 7'b110_1101;
            4'd6:    s = 7'b111_1101;
            4'd7:    s = 7'b000_0111;
            4'd8:    s = 7'b111_1111;
            4'd9:    s = 7'b110_1111;
            default: s = 7'b000_0000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int NUM_DIGITS = 8,
    parameter int ON_TICKS   = 122,
    parameter int GAP_TICKS  = 3,
    localparam int SLOT      = ON_TICKS + GAP_TICKS,
    localparam int PH_W      = $clog2(SLOT),
    localparam int IDX_W     = $clog2(NUM_DIGITS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             lit_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase <= '0;
            idx_o <= TOP_IDX;
        end else if (tick_i) begin
            if (phase == PH_W'(SLOT - 1)) begin
                phase <= '0;
                idx_o <= (idx_o == '0) ? TOP_IDX : idx_o - IDX_W'(1);
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    // Gap occupies the first GAP_TICKS phases of every slot.
    assign lit_o = (phase >= PH_W'(GAP_TICKS));

endmodule

// File: rtl/digit_blanker.sv
module digit_blanker #(
    parameter int NUM_DIGITS = 8,
    localparam int IDX_W     = $clog2(NUM_DIGITS)
) (
    input  logic [NUM_DIGITS*led_scan_pkg::BCD_W-1:0] digits_i,
    input  logic [IDX_W-1:0]                          dp_idx_i,
    input  logic                                      overflow_i,
    output logic [NUM_DIGITS-1:0]                     blank_o
);
    import led_scan_pkg::*;

    // zero_run[g]: digit g and everything above it are zero.
    logic [NUM_DIGITS:0] zero_run;
    assign zero_run[NUM_DIGITS] = 1'b1;

    for (genvar g = NUM_DIGITS - 1; g >= 0; g--) begin : g_pos
        assign zero_run[g] = zero_run[g+1] && (digits_i[g*BCD_W +: BCD_W] == '0);
        assign blank_o[g]  = zero_run[g] && (IDX_W'(g) > dp_idx_i) && !overflow_i;
    end

endmodule

// File: rtl/glyph_select.sv
module glyph_select (
    input  led_scan_pkg::bcd_t   value_i,
    input  logic                 blank_i,
    input  logic                 dp_here_i,
    input  logic                 test_i,
    output led_scan_pkg::glyph_t glyph_o
);
    import led_scan_pkg::*;

    show_e mode;

    always_comb begin
        if (test_i)       mode = SHOW_TEST;
        else if (blank_i) mode = SHOW_BLANK;
        else              mode = SHOW_VALUE;

        case (mode)
            SHOW_TEST:  glyph_o = '{seg: '1,                 dp: 1'b1};
            SHOW_BLANK: glyph_o = '{seg: '0,                 dp: dp_here_i};
            default:    glyph_o = '{seg: bcd_to_seg(value_i), dp: dp_here_i};
        endcase
    end

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top #(
    parameter int NUM_DIGITS        = 8,
    parameter int ON_TICKS          = 122,
    parameter int GAP_TICKS         = 3,
    parameter bit STROBE_ACTIVE_LOW = 1'b0,
    parameter bit SEG_ACTIVE_LOW    = 1'b0,
    localparam int IDX_W            = $clog2(NUM_DIGITS),
    localparam int DATA_W           = NUM_DIGITS * led_scan_pkg::BCD_W
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            scan_tick_i,
    input  logic [DATA_W-1:0]               digits_i,
    input  logic [IDX_W-1:0]                dp_idx_i,
    input  logic                            overflow_i,
    input  logic                            disp_test_i,
    input  logic                            disp_off_i,
    output logic [NUM_DIGITS-1:0]           strobe_o,
    output logic [led_scan_pkg::SEG_W-1:0]  seg_o,
    output logic                            dp_o,
    output logic [led_scan_pkg::BCD_W-1:0]  bcd_o
);
    import led_scan_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);

    logic [IDX_W-1:0]      idx;
    logic                  lit;
    logic [NUM_DIGITS-1:0] blank_vec;
    bcd_t                  cur_bcd;
    logic                  dp_here;
    glyph_t                glyph;

    scan_timer #(
        .NUM_DIGITS (NUM_DIGITS),
        .ON_TICKS   (ON_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (scan_tick_i),
        .idx_o  (idx),
        .lit_o  (lit)
    );

    digit_blanker #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_blank (
        .digits_i   (digits_i),
        .dp_idx_i   (dp_idx_i),
        .overflow_i (overflow_i),
        .blank_o    (blank_vec)
    );

    assign cur_bcd = digits_i[BCD_W*int'(idx) +: BCD_W];
    assign dp_here = (idx == dp_idx_i) || ((idx == TOP_IDX) && overflow_i);

    glyph_select u_glyph (
        .value_i   (cur_bcd),
        .blank_i   (blank_vec[idx]),
        .dp_here_i (dp_here),
        .test_i    (disp_test_i),
        .glyph_o   (glyph)
    );

    // Registered outputs, kept in active-high form until the pins.
    logic [NUM_DIGITS-1:0] strobe_q;
    glyph_t                glyph_q;
    bcd_t                  bcd_q;
    logic                  drive;

    assign drive = lit && !disp_off_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            strobe_q <= '0;
            glyph_q  <= '0;
            bcd_q    <= '0;
        end else begin
            strobe_q <= drive ? (NUM_DIGITS'(1) << idx) : '0;
            glyph_q  <= drive ? glyph : '0;
            bcd_q    <= disp_off_i ? '0 : cur_bcd;
        end
    end

    assign strobe_o = strobe_q ^ {NUM_DIGITS{STROBE_ACTIVE_LOW}};
    assign seg_o    = glyph_q.seg ^ {SEG_W{SEG_ACTIVE_LOW}};
    assign dp_o     = glyph_q.dp ^ SEG_ACTIVE_LOW;
    assign bcd_o    = bcd_q;

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
    parameter int NUM_DIGITS        = 8,
    parameter bit STROBE_ACTIVE_LOW = 1'b0,
    parameter bit SEG_ACTIVE_LOW    = 1'b0
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic                  scan_tick_i,
    input logic                  overflow_i,
    input logic                  disp_test_i,
    input logic                  disp_off_i,
    input logic [NUM_DIGITS-1:0] strobe_o,
    input logic [6:0]            seg_o,
    input logic                  dp_o,
    input logic [3:0]            bcd_o
);

    logic [NUM_DIGITS-1:0] s_act;
    logic [6:0]            seg_act;
    logic                  dp_act;

    assign s_act   = strobe_o ^ {NUM_DIGITS{STROBE_ACTIVE_LOW}};
    assign seg_act = seg_o ^ {7{SEG_ACTIVE_LOW}};
    assign dp_act  = dp_o ^ SEG_ACTIVE_LOW;

    assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(s_act));

    assert_dark_in_gap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_act == '0) |-> (seg_act == '0 && !dp_act));

    assert_hold_without_tick_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(scan_tick_i, 2) && ($past(disp_off_i, 1) == $past(disp_off_i, 2)))
        |-> $stable(s_act));

    assert_overflow_dp_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_act[NUM_DIGITS-1] && $past(overflow_i)) |-> dp_act);

    assert_test_all_lit_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ((s_act != '0) && $past(disp_test_i)) |-> (seg_act == 7'h7F && dp_act));

    assert_off_dark_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(disp_off_i) |-> (s_act == '0 && seg_act == '0 && !dp_act && bcd_o == 4'd0));

endmodule

bind led_scan_top led_scan_chk #(
    .NUM_DIGITS        (NUM_DIGITS),
    .STROBE_ACTIVE_LOW (STROBE_ACTIVE_LOW),
    .SEG_ACTIVE_LOW    (SEG_ACTIVE_LOW)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .scan_tick_i (scan_tick_i),
    .overflow_i  (overflow_i),
    .disp_test_i (disp_test_i),
    .disp_off_i  (disp_off_i),
    .strobe_o    (strobe_o),
    .seg_o       (seg_o),
    .dp_o        (dp_o),
    .bcd_o       (bcd_o)
);

// File: tb/tb_led_scan_top.sv
module tb_led_scan_top;

    localparam int ON  = 6;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic [31:0] digits = '0;
    logic [2:0]  dp_idx = '0;
    logic        ovf = 1'b0;
    logic        tst = 1'b0;
    logic        off = 1'b0;

    logic [7:0] strobe, strobe_n;
    logic [6:0] seg, seg_n;
    logic       dp, dp_n;
    logic [3:0] bcd, bcd_n;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    led_scan_top #(.ON_TICKS(ON), .GAP_TICKS(GAP)) dut (
        .clk_i(clk), .rst_i(rst), .scan_tick_i(tick), .digits_i(digits),
        .dp_idx_i(dp_idx), .overflow_i(ovf), .disp_test_i(tst), .disp_off_i(off),
        .strobe_o(strobe), .seg_o(seg), .dp_o(dp), .bcd_o(bcd));

    led_scan_top #(.ON_TICKS(ON), .GAP_TICKS(GAP),
                   .STROBE_ACTIVE_LOW(1'b1), .SEG_ACTIVE_LOW(1'b1)) dut_inv (
        .clk_i(clk), .rst_i(rst), .scan_tick_i(tick), .digits_i(digits),
        .dp_idx_i(dp_idx), .overflow_i(ovf), .disp_test_i(tst), .disp_off_i(off),
        .strobe_o(strobe_n), .seg_o(seg_n), .dp_o(dp_n), .bcd_o(bcd_n));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    function automatic logic [6:0] font(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
            4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
            4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
            4'd9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    function automatic logic [3:0] dig(input int k);
        return digits[4*k +: 4];
    endfunction

    // Expected {dp, seg} of digit k from the requirements.
    function automatic logic [7:0] expect_glyph(input int k);
        bit lead_zero = 1'b1;
        bit blank;
        logic dpl;
        if (tst) return 8'hFF;
        for (int j = 7; j >= k; j--) if (dig(j) != 4'd0) lead_zero = 1'b0;
        blank = lead_zero && (k > int'(dp_idx)) && !ovf;
        dpl = (k == int'(dp_idx)) || (k == 7 && ovf);
        return {dpl, blank ? 7'h00 : font(dig(k))};
    endfunction

    task automatic check_inv(input string req);
        check(strobe_n == ~strobe && seg_n == ~seg && dp_n == ~dp && bcd_n == bcd,
              req, {strobe_n, seg_n, dp_n, bcd_n}, {~strobe, ~seg, ~dp, bcd});
    endtask

    // Sync to the start of D8's lit phase, then check one whole frame.
    task automatic observe_frame(input string req);
        logic [7:0] prev;
        int guard = 0;
        bit first = 1'b1;
        @(negedge clk);
        prev = strobe;
        forever begin
            @(negedge clk);
            if (strobe == 8'h80 && prev == 8'h00) break;
            prev = strobe;
            guard++;
            if (guard > 400) begin
                check(1'b0, {req, " R1 sync to D8"}, {24'd0, strobe}, 32'h80);
                return;
            end
        end
        for (int k = 7; k >= 0; k--) begin
            for (int c = 0; c < ON; c++) begin
                if (!first) @(negedge clk);
                first = 1'b0;
                check(strobe == (8'h01 << k), {req, " R1 R2 strobe"}, {24'd0, strobe},
                      32'(8'h01 << k));
                check({dp, seg} == expect_glyph(k), {req, " R5 R6 R8 glyph"},
                      {24'd0, dp, seg}, {24'd0, expect_glyph(k)});
                check(bcd == dig(k), {req, " R3 bcd lit"}, {28'd0, bcd}, {28'd0, dig(k)});
                check_inv({req, " R11 polarity"});
            end
            for (int c = 0; c < GAP; c++) begin
                @(negedge clk);
                check(strobe == 8'h00 && seg == 7'h00 && !dp, {req, " R2 gap dark"},
                      {23'd0, strobe, dp, seg}, 32'd0);
                check(bcd == dig(k == 0 ? 7 : k - 1), {req, " R3 bcd leads strobe"},
                      {28'd0, bcd}, {28'd0, dig(k == 0 ? 7 : k - 1)});
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(strobe == 8'h00 && seg == 7'h00 && !dp && bcd == 4'd0, "R12 reset state",
              {19'd0, strobe, dp, seg, bcd}, 32'd0);
        check(strobe_n == 8'hFF && seg_n == 7'h7F && dp_n, "R12 R11 reset inverted",
              {24'd0, strobe_n}, 32'hFF);
        rst = 1'b0;
    endtask

    task automatic t_plain_blanking();
        digits = 32'h0000_4567; dp_idx = 3'd1; ovf = 1'b0;
        observe_frame("R6 leading zeros above D2");
    endtask

    task automatic t_interior_zero();
        digits = 32'h0010_2030; dp_idx = 3'd3;
        observe_frame("R6 interior zeros kept");
    endtask

    task automatic t_all_zero();
        digits = 32'h0000_0000; dp_idx = 3'd4;
        observe_frame("R6 all zero dp at D5");
    endtask

    task automatic t_font_nonbcd();
        digits = 32'h0A98_FB12; dp_idx = 3'd7;
        observe_frame("R5 font and non-decimal codes");
        digits = 32'h3456_7890; dp_idx = 3'd0;
        observe_frame("R5 R8 full font dp D1");
    endtask

    task automatic t_overflow();
        digits = 32'h0000_0012; dp_idx = 3'd2; ovf = 1'b1;
        observe_frame("R7 overflow no blanking");
        ovf = 1'b0;
    endtask

    task automatic t_test();
        digits = 32'h0000_0305; dp_idx = 3'd0; tst = 1'b1;
        observe_frame("R9 display test");
    endtask

    task automatic t_off();
        tst = 1'b1; off = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 8 * (ON + GAP) + 4; c++) begin
            @(negedge clk);
            check(strobe == 8'h00 && seg == 7'h00 && !dp && bcd == 4'd0,
                  "R10 off over test", {19'd0, strobe, dp, seg, bcd}, 32'd0);
        end
        off = 1'b0; tst = 1'b0;
        observe_frame("R10 recovery after off");
    endtask

    task automatic t_tick_hold();
        logic [7:0] s0;
        digits = 32'h1234_5678; dp_idx = 3'd0;
        // Wait until a strobe is lit, then stop the tick.
        do @(negedge clk); while (strobe == 8'h00);
        tick = 1'b0;
        @(negedge clk);
        s0 = strobe;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check(strobe == s0, "R4 no advance without tick", {24'd0, strobe}, {24'd0, s0});
        end
        tick = 1'b1;
        observe_frame("R4 resumes with tick");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_plain_blanking();
        t_interior_zero();
        t_all_zero();
        t_font_nonbcd();
        t_overflow();
        t_test();
        t_off();
        t_tick_hold();
        summary();
        $finish;
    end

endmodule